// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the read-only line status flags of a UART that has receive and transmit FIFOs. It reports whether received data is waiting, whether a character was lost to a full receive FIFO, and the parity, framing and break errors of the character now at the head of the receive FIFO. It also reports whether the transmit holding stage is free and whether the whole transmitter is idle. A summary flag says that at least one character carrying an error is still queued in the receive FIFO.

The FIFO storage and the serial datapaths live outside the block. They tell it when a character is pushed or popped, which error tags the pushed entry and the head entry carry, and when a new entry reaches the head. A strobe marks each read of the status register, and another marks each write to the transmit holding register.

Every flag is a register that updates on the clock edge that samples its cause. Status reads clear the error flags. Where a new event and a clearing read land on the same edge, the event wins. All pins are plain level or strobe signals: data does not cross the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `uart_line_status`

## Requirements
- R1: After reset, stat_ready, stat_overrun, stat_parity, stat_frame, stat_break and stat_fifo_err are 0, and stat_thre and stat_temt are 1.
- R2: stat_ready equals the inverse of rx_empty sampled on the previous edge. A status read never changes it.
- R3: stat_overrun becomes 1 after an edge where rx_char_done and rx_full are both high. Otherwise a status_rd clears it. When both happen on the same edge, it is set.
- R4: Error tag bit positions are 0 for parity, 1 for framing and 2 for break. On an edge with rx_head_new, stat_parity, stat_frame and stat_break load the bits of rx_head_tag. Otherwise status_rd clears them, and without either they hold.
- R5: stat_thre becomes 0 after an edge with thr_wr. Otherwise it becomes 1 after an edge with tx_hold_empty high, and otherwise it holds.
- R6: stat_temt equals tx_hold_empty AND tx_shift_empty from the previous edge.
- R7: The FIFO error flag sets after an edge where rx_push has a nonzero rx_push_tag. This set takes priority over a clearing read on the same edge.
- R8: A status_rd clears the FIFO error flag only when the queued error count (its value before that edge) is zero. Otherwise the flag stays set.
- R9: The queued error count rises on a push with a nonzero rx_push_tag. It falls on a pop when the popped entry's rx_head_tag is nonzero. A push and a pop on the same edge that both carry errors leave it unchanged.
- R10: stat_fifo_err reads 0 whenever fifo_en is low, with no delay. The held flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| rx_push | input | 1 | A character is written into the receive FIFO |
| rx_push_tag | input | 3 | Error tag of the pushed character |
| rx_pop | input | 1 | The head entry is removed from the receive FIFO |
| rx_head_new | input | 1 | A new entry reaches the head of the receive FIFO |
| rx_head_tag | input | 3 | Error tag of the head entry |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_char_done | input | 1 | The receiver finished a character |
| status_rd | input | 1 | The status register is being read |
| thr_wr | input | 1 | Write to the transmit holding register |
| tx_hold_empty | input | 1 | Transmit holding stage is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| stat_ready | output | 1 | Received data available |
| stat_overrun | output | 1 | A character was lost to a full FIFO |
| stat_parity | output | 1 | Head character has a parity error |
| stat_frame | output | 1 | Head character has a framing error |
| stat_break | output | 1 | Head character is a break |
| stat_thre | output | 1 | Transmit holding stage empty |
| stat_temt | output | 1 | Transmitter fully empty |
| stat_fifo_err | output | 1 | An erroneous character is queued |

## Verification
All flags except the enable gating are due one edge after the stimulus. The bench therefore drives inputs on the falling edge and updates its own expected state right after the next rising edge, from the values it drove. It then compares every output 2 ns later, before it drives anything new. Gating by fifo_en has no delay, so that check is made 1 ns after fifo_en changes, with no clock edge in between. The count that limits clearing of the summary flag is modelled as the value before the edge, which matches how R8 is worded.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int TAG_W   = 3;
  localparam int TAG_PAR = 0;
  localparam int TAG_FRM = 1;
  localparam int TAG_BRK = 2;
  typedef logic [TAG_W-1:0] err_tag_t;
endpackage

// File: rtl/uls_err_count.sv
module uls_err_count
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  err_tag_t push_tag,
  input  logic     pop,
  input  err_tag_t pop_tag,
  output logic     cnt_zero
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic inc, dec;

  assign inc = push & (|push_tag);
  assign dec = pop & (|pop_tag);

  // R9: count of erroneous entries queued in the receive FIFO
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/uls_rx_flags.sv
module uls_rx_flags
  import uls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_en,
  input  logic     rd,
  input  logic     char_done,
  input  logic     full,
  input  logic     empty,
  input  logic     head_new,
  input  err_tag_t head_tag,
  input  logic     push,
  input  err_tag_t push_tag,
  input  logic     cnt_zero,
  output logic     ready,
  output logic     overrun,
  output err_tag_t head_err,
  output logic     fifo_err
);
  logic ready_q, ovr_q, ferr_q;

  // R2: data available, not touched by reads
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ~empty;
  end

  // R3: lost character, set wins over read clear
  always_ff @(posedge clk) begin
    if (!rst_n)                 ovr_q <= 1'b0;
    else if (char_done && full) ovr_q <= 1'b1;
    else if (rd)                ovr_q <= 1'b0;
  end

  // R4: one flag per tag bit, follows the head entry
  for (genvar g = 0; g < TAG_W; g++) begin : g_head
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (head_new) bit_q <= head_tag[g];
      else if (rd)       bit_q <= 1'b0;
    end
    assign head_err[g] = bit_q;
  end

  // R7, R8: sticky summary, read clears only with nothing queued
  always_ff @(posedge clk) begin
    if (!rst_n)                  ferr_q <= 1'b0;
    else if (push && |push_tag)  ferr_q <= 1'b1;
    else if (rd && cnt_zero)     ferr_q <= 1'b0;
  end

  assign ready    = ready_q;
  assign overrun  = ovr_q;
  assign fifo_err = ferr_q & fifo_en;   // R10
endmodule

// File: rtl/uls_tx_flags.sv
module uls_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic hold_empty,
  input  logic shift_empty,
  output logic thre,
  output logic temt
);
  logic thre_q, temt_q;

  // R5: write clears, empty holding stage sets
  always_ff @(posedge clk) begin
    if (!rst_n)          thre_q <= 1'b1;
    else if (thr_wr)     thre_q <= 1'b0;
    else if (hold_empty) thre_q <= 1'b1;
  end

  // R6: both stages empty
  always_ff @(posedge clk) begin
    if (!rst_n) temt_q <= 1'b1;
    else        temt_q <= hold_empty & shift_empty;
  end

  assign thre = thre_q;
  assign temt = temt_q;
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_push,
  input  logic [2:0] rx_push_tag,
  input  logic       rx_pop,
  input  logic       rx_head_new,
  input  logic [2:0] rx_head_tag,
  input  logic       rx_empty,
  input  logic       rx_full,
  input  logic       rx_char_done,
  input  logic       status_rd,
  input  logic       thr_wr,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  output logic       stat_ready,
  output logic       stat_overrun,
  output logic       stat_parity,
  output logic       stat_frame,
  output logic       stat_break,
  output logic       stat_thre,
  output logic       stat_temt,
  output logic       stat_fifo_err
);
  logic     cnt_zero;
  err_tag_t head_err;

  uls_err_count #(.DEPTH(FIFO_DEPTH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rx_push),
    .push_tag (rx_push_tag),
    .pop      (rx_pop),
    .pop_tag  (rx_head_tag),
    .cnt_zero (cnt_zero)
  );

  uls_rx_flags u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .rd        (status_rd),
    .char_done (rx_char_done),
    .full      (rx_full),
    .empty     (rx_empty),
    .head_new  (rx_head_new),
    .head_tag  (rx_head_tag),
    .push      (rx_push),
    .push_tag  (rx_push_tag),
    .cnt_zero  (cnt_zero),
    .ready     (stat_ready),
    .overrun   (stat_overrun),
    .head_err  (head_err),
    .fifo_err  (stat_fifo_err)
  );

  uls_tx_flags u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_wr      (thr_wr),
    .hold_empty  (tx_hold_empty),
    .shift_empty (tx_shift_empty),
    .thre        (stat_thre),
    .temt        (stat_temt)
  );

  assign stat_parity = head_err[TAG_PAR];
  assign stat_frame  = head_err[TAG_FRM];
  assign stat_break  = head_err[TAG_BRK];
endmodule

// File: rtl/uls_checker.sv
module uls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       rx_push,
  input logic [2:0] rx_push_tag,
  input logic       rx_head_new,
  input logic [2:0] rx_head_tag,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       rx_char_done,
  input logic       status_rd,
  input logic       thr_wr,
  input logic       tx_hold_empty,
  input logic       tx_shift_empty,
  input logic       stat_ready,
  input logic       stat_overrun,
  input logic       stat_frame,
  input logic       stat_break,
  input logic       stat_thre,
  input logic       stat_temt,
  input logic       stat_fifo_err
);
  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (stat_ready == !$past(rx_empty)));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_done && rx_full) |=> stat_overrun);

  assert_overrun_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(rx_char_done && rx_full)) |=> !stat_overrun);

  assert_head_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !rx_head_new) |=> (!stat_frame && !stat_break));

  assert_head_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_head_new |=> (stat_frame == $past(rx_head_tag[1]) && stat_break == $past(rx_head_tag[2])));

  assert_thre_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !stat_thre);

  assert_temt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hold_empty && tx_shift_empty) |=> stat_temt);

  assert_temt_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_shift_empty |=> !stat_temt);

  assert_fifo_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_push && |rx_push_tag && $past(fifo_en)) |=> (stat_fifo_err || !fifo_en));

  assert_fifo_err_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !stat_fifo_err);
endmodule

bind uart_line_status uls_checker u_chk (.*);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, fifo_en, rx_push, rx_pop, rx_head_new, rx_empty, rx_full;
  logic       rx_char_done, status_rd, thr_wr, tx_hold_empty, tx_shift_empty;
  logic [2:0] rx_push_tag, rx_head_tag;
  logic       stat_ready, stat_overrun, stat_parity, stat_frame, stat_break;
  logic       stat_thre, stat_temt, stat_fifo_err;

  uart_line_status #(.FIFO_DEPTH(DEPTH)) uut (.*);

  int total = 0;
  int bad   = 0;

  logic       m_ready, m_ov, m_thre, m_temt, m_ferr;
  logic [2:0] m_tag;
  int         m_cnt;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2", "stat_ready",    stat_ready,    m_ready);
    chk("R3", "stat_overrun",  stat_overrun,  m_ov);
    chk("R4", "stat_parity",   stat_parity,   m_tag[0]);
    chk("R4", "stat_frame",    stat_frame,    m_tag[1]);
    chk("R4", "stat_break",    stat_break,    m_tag[2]);
    chk("R5", "stat_thre",     stat_thre,     m_thre);
    chk("R6", "stat_temt",     stat_temt,     m_temt);
    chk("R7 R8 R9 R10", "stat_fifo_err", stat_fifo_err, m_ferr & fifo_en);
  endtask

  task automatic model_step();
    logic inc, dec;
    inc = rx_push & (|rx_push_tag);
    dec = rx_pop & (|rx_head_tag);
    m_ready = ~rx_empty;
    if (rx_char_done && rx_full) m_ov = 1'b1; else if (status_rd) m_ov = 1'b0;
    if (rx_head_new) m_tag = rx_head_tag; else if (status_rd) m_tag = 3'b000;
    if (thr_wr) m_thre = 1'b0; else if (tx_hold_empty) m_thre = 1'b1;
    m_temt = tx_hold_empty & tx_shift_empty;
    if (inc) m_ferr = 1'b1; else if (status_rd && m_cnt == 0) m_ferr = 1'b0;
    m_cnt = m_cnt + int'(inc) - int'(dec);
  endtask

  task automatic legalize();
    if (rx_push && |rx_push_tag && m_cnt == DEPTH) rx_push = 1'b0;
    if (rx_pop && |rx_head_tag && m_cnt == 0) rx_pop = 1'b0;
  endtask

  task automatic cycle();
    legalize();
    @(posedge clk);
    model_step();
    #2;
    check_all();
    @(negedge clk);
  endtask

  task automatic idle();
    fifo_en = 1'b1; rx_push = 0; rx_push_tag = 0; rx_pop = 0; rx_head_new = 0;
    rx_head_tag = 0; rx_empty = 1; rx_full = 0; rx_char_done = 0; status_rd = 0;
    thr_wr = 0; tx_hold_empty = 1; tx_shift_empty = 1;
  endtask

  initial begin
    #(20 * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    m_ready = 0; m_ov = 0; m_thre = 1; m_temt = 1; m_ferr = 0; m_tag = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset values
    chk("R1", "stat_ready",    stat_ready,    1'b0);
    chk("R1", "stat_overrun",  stat_overrun,  1'b0);
    chk("R1", "stat_parity",   stat_parity,   1'b0);
    chk("R1", "stat_frame",    stat_frame,    1'b0);
    chk("R1", "stat_break",    stat_break,    1'b0);
    chk("R1", "stat_thre",     stat_thre,     1'b1);
    chk("R1", "stat_temt",     stat_temt,     1'b1);
    chk("R1", "stat_fifo_err", stat_fifo_err, 1'b0);
    @(negedge clk);

    // exhaustive sweep of the non-counting controls
    for (int i = 0; i < 1024; i++) begin
      idle();
      status_rd      = i[0];
      rx_char_done   = i[1];
      rx_full        = i[2];
      rx_head_new    = i[3];
      rx_head_tag    = i[6:4];
      thr_wr         = i[7];
      tx_hold_empty  = i[8];
      tx_shift_empty = i[9];
      rx_empty       = i[1] ^ i[4];
      cycle();
    end

    // pseudo-random sweep including pushes, pops and enable
    for (int i = 0; i < 4000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      fifo_en        = (seed[30:28] != 3'd0);
      rx_push        = seed[27];
      rx_push_tag    = seed[26:24] & seed[23:21];
      rx_pop         = seed[20];
      rx_head_new    = seed[19];
      rx_head_tag    = seed[18:16] & seed[15:13];
      rx_empty       = seed[12];
      rx_full        = seed[11];
      rx_char_done   = seed[10];
      status_rd      = seed[9] & seed[8];
      thr_wr         = seed[7];
      tx_hold_empty  = seed[6];
      tx_shift_empty = seed[5];
      cycle();
    end

    // drain queued errors
    idle();
    while (m_cnt > 0) begin
      rx_pop = 1; rx_head_tag = 3'b001; cycle();
    end
    idle(); status_rd = 1; cycle();

    // R8 / R9: read with an error queued keeps the flag
    idle(); rx_push = 1; rx_push_tag = 3'b010; cycle();
    idle(); status_rd = 1; cycle();
    chk("R8", "fifo_err kept with count 1", stat_fifo_err, 1'b1);
    idle(); rx_pop = 1; rx_head_tag = 3'b010; cycle();
    idle(); status_rd = 1; cycle();
    chk("R8 R9", "fifo_err cleared after pop", stat_fifo_err, 1'b0);

    // R7: set wins over clearing read on the same edge
    idle(); rx_push = 1; rx_push_tag = 3'b100; status_rd = 1; cycle();
    chk("R7", "fifo_err set priority", stat_fifo_err, 1'b1);

    // R10: gating is immediate, held flag survives
    idle(); fifo_en = 1'b0; #1;
    chk("R10", "fifo_err gated", stat_fifo_err, 1'b0);
    @(negedge clk);
    fifo_en = 1'b1; #1;
    chk("R10", "fifo_err restored", stat_fifo_err, 1'b1);
    @(negedge clk);

    // R3 / R4: set priority over read
    idle(); rx_char_done = 1; rx_full = 1; rx_head_new = 1; rx_head_tag = 3'b011;
    status_rd = 1; cycle();
    chk("R3", "overrun set priority", stat_overrun, 1'b1);
    chk("R4", "frame loaded despite read", stat_frame, 1'b1);
    idle(); status_rd = 1; cycle();
    chk("R2", "ready after read", stat_ready, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule